// File: doc/BRIEF.md
# ADC Result Readout Register Interface

This block sits between a host bus and an analog-to-digital converter. It holds the most recent conversion result and presents it as two byte-wide read registers, one for the low byte and one for the high byte. A word-wide read at the low-byte offset returns both bytes at once. The result is captured when the converter pulses its completion strobe. A completion flag and an optional interrupt then tell software that data is waiting.

The addresses of the two registers depend on a mapping-mode input. In the narrow (8-bit bus) mapping, the pair sits at 0x303/0x304. In the wide (16-bit bus) mapping, the pair moves up by one to 0x304/0x305, so that the pair starts on an even address. Results narrower than 16 bits are sign-extended into the unused upper bits.

Reading the high byte is the point where software has finished with a result, so that read carries side effects:
- the completion flag clears;
- the interrupt drops;
- when enabled, the channel selector advances;
- when enabled, a new conversion is started with a one-cycle pulse.

Top module: `adc_result_regs`

## Requirements
- R1: With `wide_map`=0, a byte read at offset 0x303 returns the low byte and a byte read at 0x304 returns the high byte.
- R2: With `wide_map`=1, a byte read at offset 0x304 returns the low byte and a byte read at 0x305 returns the high byte.
- R3: Any accepted read sets `rd_valid` for exactly the following cycle, with data in `rd_data`. A byte read places its byte in `rd_data[7:0]`, with `rd_data[15:8]`=0. The low byte is result bits 7..0 and the high byte is result bits 15..8.
- R4: With a 12-bit result, bit 11 is replicated into high-byte bits 7..4.
- R5: A word read (`rd_word`=1) at the low-byte offset returns the high byte in `rd_data[15:8]` and the low byte in `rd_data[7:0]`, in either mapping.
- R6: A `cnv_done` pulse latches `cnv_data`, and `done_flag` is 1 from the next cycle. If a high-byte read happens in the same cycle, the new result wins: the flag stays set and the read returns the old result.
- R7: A high-byte read (byte read at the high offset, or word read) clears `done_flag` from the next cycle.
- R8: `irq` follows `done_flag` while `irq_en`=1 and is 0 otherwise. A high-byte read drops it from the next cycle.
- R9: With `auto_inc`=1, a high-byte read advances `channel` by one, wrapping from 15 to 0. With `auto_inc`=0, `channel` holds.
- R10: With `auto_trig`=1, a high-byte read gives a `cnv_start` pulse one cycle wide, in the next cycle. With `auto_trig`=0, there is no pulse.
- R11: A low-byte byte read changes neither `done_flag`, `irq`, `channel` nor `cnv_start`. A word read applies the high-byte side effects exactly once.
- R12: A read at any other offset, or a word read at the high offset, gives no `rd_valid` and no side effect.
- R13: After reset, `done_flag`, `irq`, `cnv_start`, `rd_valid` and `channel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_map | input | 1 | 0: 8-bit register mapping, 1: 16-bit mapping |
| rd_en | input | 1 | Read request this cycle |
| rd_word | input | 1 | Read request is word-wide |
| rd_addr | input | 10 | Bus offset of the read |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| cnv_done | input | 1 | Converter completion strobe |
| cnv_data | input | 12 | Converter result, sampled with cnv_done |
| irq_en | input | 1 | ADC interrupt enable |
| auto_inc | input | 1 | Advance channel on high-byte read |
| auto_trig | input | 1 | Start a conversion on high-byte read |
| done_flag | output | 1 | Unread result present |
| irq | output | 1 | ADC interrupt request |
| channel | output | 4 | Selected input channel |
| cnv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The embedded assertions check the cycle-level rules on every clock:
- a strobe sets the flag one cycle later;
- a high-byte read without a strobe clears the flag and the interrupt;
- the channel steps by one or holds;
- the start pulse lasts one cycle and appears only after a high-byte read with auto-trigger set;
- a low-byte read disturbs nothing.

Only the bench scenarios can show that data reaches the bus intact. They check:
- the offset decode in both mappings;
- the byte order of word reads;
- sign extension of negative results;
- the channel wrap from 15 to 0;
- that unmapped offsets return nothing.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned NARROW_LO_OFS = 32'h303;
  localparam int unsigned WIDE_LO_OFS   = 32'h304;
  localparam int unsigned WORD_W        = 16;
  localparam int unsigned BYTE_W        = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_WORD = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
  import adc_rd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              wide_map,
  input  logic              rd_en,
  input  logic              rd_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output rd_sel_e           sel,
  output logic              hi_side
);
  localparam logic [ADDR_W-1:0] LO_N = ADDR_W'(NARROW_LO_OFS);
  localparam logic [ADDR_W-1:0] LO_W = ADDR_W'(WIDE_LO_OFS);

  logic [ADDR_W-1:0] lo_ofs, hi_ofs;

  always_comb begin
    lo_ofs = wide_map ? LO_W : LO_N;
    hi_ofs = lo_ofs + ADDR_W'(1);
    sel    = SEL_NONE;
    if (rd_en) begin
      if (rd_word) begin
        if (rd_addr == lo_ofs) sel = SEL_WORD;
      end else if (rd_addr == lo_ofs) begin
        sel = SEL_LO;
      end else if (rd_addr == hi_ofs) begin
        sel = SEL_HI;
      end
    end
    hi_side = (sel == SEL_HI) || (sel == SEL_WORD);
  end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_rd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_data,
  input  logic              hi_side,
  input  logic              irq_en,
  output logic [WORD_W-1:0] result,
  output logic              done_flag,
  output logic              irq
);
  logic [WORD_W-1:0] ext;
  logic              done_n;

  generate
    if (RES_W < WORD_W) begin : g_sext
      assign ext = {{(WORD_W-RES_W){cnv_data[RES_W-1]}}, cnv_data};
    end else begin : g_full
      assign ext = cnv_data[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    if (cnv_done)     done_n = 1'b1;
    else if (hi_side) done_n = 1'b0;
    else              done_n = done_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      done_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (cnv_done) result <= ext;
      done_flag <= done_n;
      irq       <= done_n & irq_en;
    end
  end

  assert_done_set_R6: assert property (@(posedge clk) disable iff (rst)
    cnv_done |=> done_flag);
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (hi_side && !cnv_done) |=> !done_flag);
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (hi_side && !cnv_done) |=> !irq);
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (cnv_done && irq_en) |=> irq);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hi_side,
  input  logic            auto_inc,
  input  logic            auto_trig,
  output logic [CH_W-1:0] channel,
  output logic            cnv_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      channel   <= '0;
      cnv_start <= 1'b0;
    end else begin
      if (hi_side && auto_inc) channel <= channel + CH_W'(1);
      cnv_start <= hi_side && auto_trig;
    end
  end

  assert_ch_step_R9: assert property (@(posedge clk) disable iff (rst)
    (hi_side && auto_inc) |=> channel == $past(channel) + CH_W'(1));
  assert_ch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(hi_side && auto_inc) |=> $stable(channel));
  assert_start_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_start) |-> $past(hi_side && auto_trig));
  assert_start_off_R10: assert property (@(posedge clk) disable iff (rst)
    !(hi_side && auto_trig) |=> !cnv_start);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RES_W  = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_map,
  input  logic              rd_en,
  input  logic              rd_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_data,
  input  logic              irq_en,
  input  logic              auto_inc,
  input  logic              auto_trig,
  output logic              done_flag,
  output logic              irq,
  output logic [CH_W-1:0]   channel,
  output logic              cnv_start
);
  rd_sel_e           sel;
  logic              hi_side;
  logic [WORD_W-1:0] result;

  adc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wide_map(wide_map), .rd_en(rd_en), .rd_word(rd_word),
    .rd_addr(rd_addr), .sel(sel), .hi_side(hi_side)
  );

  adc_result_hold #(.RES_W(RES_W)) u_hold (
    .clk(clk), .rst(rst), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .hi_side(hi_side), .irq_en(irq_en), .result(result),
    .done_flag(done_flag), .irq(irq)
  );

  adc_seq_ctrl #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .hi_side(hi_side), .auto_inc(auto_inc),
    .auto_trig(auto_trig), .channel(channel), .cnv_start(cnv_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (sel != SEL_NONE);
      unique case (sel)
        SEL_LO:   rd_data <= {8'h00, result[BYTE_W-1:0]};
        SEL_HI:   rd_data <= {8'h00, result[WORD_W-1:BYTE_W]};
        SEL_WORD: rd_data <= result;
        default:  rd_data <= '0;
      endcase
    end
  end

  assert_lo_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_LO && !cnv_done) |=> ($stable(done_flag) && !cnv_start));
  assert_narrow_map_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_word && !wide_map && rd_addr == ADDR_W'(12'h303)) |=> rd_valid);
  assert_wide_map_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_word && wide_map && rd_addr == ADDR_W'(12'h305)) |=> rd_valid);
  assert_no_req_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/test_adc_result_regs.sv
module test_adc_result_regs;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_map = 1'b0, rd_en = 1'b0, rd_word = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        cnv_done = 1'b0;
  logic [11:0] cnv_data = '0;
  logic        irq_en = 1'b0, auto_inc = 1'b0, auto_trig = 1'b0;
  logic        done_flag, irq, cnv_start;
  logic [3:0]  channel;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  adc_result_regs i_adc_result_regs (
    .clk(clk), .rst(rst), .wide_map(wide_map), .rd_en(rd_en),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .irq_en(irq_en), .auto_inc(auto_inc), .auto_trig(auto_trig),
    .done_flag(done_flag), .irq(irq), .channel(channel),
    .cnv_start(cnv_start)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per valid read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 actual rd_valid=1 expected rd_valid=0");
      end else begin
        string t;
        logic [15:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  // Driver: one-cycle read; expectation pushed when mapped
  task automatic do_read(input logic [9:0] a, input logic w, input bit hit,
                         input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_word = w;
    if (hit) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(negedge clk);
    rd_en = 1'b0; rd_word = 1'b0;
  endtask

  task automatic convert(input logic [11:0] d);
    @(negedge clk);
    cnv_done = 1'b1; cnv_data = d;
    @(negedge clk);
    cnv_done = 1'b0;
  endtask

  initial begin
    #(PERIOD*20000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    if (!finished) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check("R13 done", {15'd0, done_flag}, 16'd0);
    check("R13 irq", {15'd0, irq}, 16'd0);
    check("R13 start", {15'd0, cnv_start}, 16'd0);
    check("R13 valid", {15'd0, rd_valid}, 16'd0);
    check("R13 channel", {12'd0, channel}, 16'd0);

    // R6, R8 capture with interrupts enabled
    irq_en = 1'b1;
    convert(12'h3F1);
    check("R6 done set", {15'd0, done_flag}, 16'd1);
    check("R8 irq set", {15'd0, irq}, 16'd1);

    // R1 narrow mapping, R3 byte contents, R11 low read quiet
    do_read(10'h303, 1'b0, 1, 16'h00F1, "R1 lo");
    check("R11 done kept", {15'd0, done_flag}, 16'd1);
    check("R11 channel kept", {12'd0, channel}, 16'd0);
    check("R11 no start", {15'd0, cnv_start}, 16'd0);
    do_read(10'h304, 1'b0, 1, 16'h0003, "R1 hi");
    check("R7 done cleared", {15'd0, done_flag}, 16'd0);
    check("R8 irq cleared", {15'd0, irq}, 16'd0);
    check("R9 no inc when off", {12'd0, channel}, 16'd0);
    check("R10 no start when off", {15'd0, cnv_start}, 16'd0);

    // R4 sign extension, R2 wide mapping
    wide_map = 1'b1;
    convert(12'hA5C);
    do_read(10'h304, 1'b0, 1, 16'h005C, "R2 lo");
    do_read(10'h305, 1'b0, 1, 16'h00FA, "R4 hi sext");
    // R5 word read in both mappings
    do_read(10'h304, 1'b1, 1, 16'hFA5C, "R5 word wide");
    wide_map = 1'b0;
    do_read(10'h303, 1'b1, 1, 16'hFA5C, "R5 word narrow");

    // R12 unmapped and word at high offset: no response, no side effects
    convert(12'h123);
    auto_inc = 1'b1; auto_trig = 1'b1;
    do_read(10'h305, 1'b0, 0, 16'h0, "R12");
    check("R12 done kept", {15'd0, done_flag}, 16'd1);
    do_read(10'h304, 1'b1, 0, 16'h0, "R12");
    check("R12 channel kept", {12'd0, channel}, 16'd0);
    check("R12 no start", {15'd0, cnv_start}, 16'd0);

    // R11 word read side effects once, R9 step, R10 pulse
    do_read(10'h303, 1'b1, 1, 16'h0123, "R11 word");
    check("R11 word step once", {12'd0, channel}, 16'd1);
    check("R10 start pulse", {15'd0, cnv_start}, 16'd1);
    check("R11 word clears done", {15'd0, done_flag}, 16'd0);
    @(negedge clk);
    check("R10 pulse one cycle", {15'd0, cnv_start}, 16'd0);

    // R9 wrap 15 -> 0
    for (int i = 0; i < 14; i++) do_read(10'h304, 1'b0, 1, 16'h0001, "R9 hi");
    check("R9 channel 15", {12'd0, channel}, 16'd15);
    do_read(10'h304, 1'b0, 1, 16'h0001, "R9 hi");
    check("R9 wrap", {12'd0, channel}, 16'd0);

    // R6 strobe wins over simultaneous high read; old data returned
    @(negedge clk);
    cnv_done = 1'b1; cnv_data = 12'h7E4;
    rd_en = 1'b1; rd_addr = 10'h304; rd_word = 1'b0;
    exp_q.push_back(16'h0001); tag_q.push_back("R6 old data");
    @(negedge clk);
    cnv_done = 1'b0; rd_en = 1'b0;
    check("R6 strobe wins", {15'd0, done_flag}, 16'd1);
    // R8 irq gated by enable
    irq_en = 1'b0;
    @(negedge clk);
    check("R8 irq off when disabled", {15'd0, irq}, 16'd0);
    do_read(10'h303, 1'b1, 1, 16'h07E4, "R5 word new");

    repeat (3) @(negedge clk);
    check("R3 all reads answered", 16'(exp_q.size()), 16'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule